// File: doc/BRIEF.md
# Activity Threshold and Power State Controller

This block decides whether a battery monitor is counting, asleep, or calibrating its offset. Each cycle it receives a signed sense measurement, the level of the host data line and a one-second tick. It compares the size of the measurement against a wake threshold that a 3-bit code in the mode register selects. The block drives an open-drain wake indication low while the current is large. When it is not large, the indication is released.

The block tracks how long the data line has been low while the current stays small. Once that has lasted longer than ten seconds, the block stops the charge counters. It then either sleeps or, if the host has armed it, starts a one-hour offset calibration. If calibration runs the full hour undisturbed, the block stores the measured offset as an 8-bit two's-complement value, clears the arm bit and pulses a done flag. A high data line, or a large current, cancels calibration and leaves the stored offset as it was. A high data line also ends sleep.

Top module: `activity_power_ctrl`

## Requirements
- R1: After reset the mode register reads 0x0E (threshold code 7, arm bit clear), the offset register reads 0x00, the wake output is released (0), counting is enabled (1) and the done flag is 0.
- R2: The threshold code is mode bits [3:1]. The measurement counts as large when the code is nonzero and |measurement| times the code is greater than FS_LSB (default 307, a 3.84 mV full scale in 12.5 uV steps). With code 0 the measurement is never large.
- R3: The wake output is 1 (pull low) in the cycle after a clock edge that saw a large measurement, and 0 (released) otherwise.
- R4: While running, the block counts ticks that arrive with the data line low and the measurement not large. A high line or a large measurement clears that count. The eleventh consecutive qualifying tick stops counting (count enable goes to 0) from the next cycle.
- R5: A high data line while sleeping or calibrating returns the block to running, with count enable back to 1, in the next cycle.
- R6: If mode bit 6 (arm) is set when the eleventh qualifying tick arrives, the block enters calibration instead of sleep. Counting stops and the arm bit stays set.
- R7: In calibration, the 3600th tick that arrives with the line low and the measurement not large completes calibration. The offset register loads the measurement, bit 6 clears, the done flag is 1 for exactly one cycle, and the block then sleeps.
- R8: A large measurement during calibration aborts it and the block returns to running. The offset register and the arm bit are unchanged.
- R9: A host write (mode_we high) loads mode_wdata into the mode register at the next edge.
- R10: The latched offset saturates: measurements above 127 store 0x7F, and measurements below -128 store 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_val | input | MEAS_W | Signed offset-adjusted sense measurement |
| line_hi | input | 1 | Host data line level |
| sec_tick | input | 1 | One-cycle pulse per second |
| mode_we | input | 1 | Host write strobe for the mode register |
| mode_wdata | input | 8 | Host write data for the mode register |
| wake_pull_low | output | 1 | 1 = wake pin driven low, 0 = high-Z |
| count_en | output | 1 | Charge/discharge counting enabled |
| offset_q | output | 8 | Offset register (two's complement) |
| mode_q | output | 8 | Mode register contents |
| cal_done | output | 1 | One-cycle pulse when calibration completes |

## Verification
The bench probes the threshold exactly at |v|·N = FS_LSB and one step above, for both signs and for codes 1, 7 and 0. A design that uses >= instead of >, or that drops the sign, would assert wake at the wrong point. An idle line that is interrupted at ten ticks checks that the low-time count really restarts. A design off by one in the count would sleep too early or too late. The bench runs calibration through the full 3600-tick window, including an abort and two saturating offsets. A design would fail here if it latched one tick early, kept the arm bit set, changed the offset on abort, or wrapped the offset value instead of clamping it.

// File: rtl/wpc_pkg.sv
// Shared types and constants for the activity/power controller.
// Assumes: mode register is 8 bits wide with the code in bits [3:1].
package wpc_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_SLEEP = 2'd1,
        PS_CAL   = 2'd2
    } pstate_t;

    localparam int ARM_BIT   = 6;
    localparam int CODE_LSB  = 1;
    localparam int CODE_W    = 3;
    localparam logic [7:0] MODE_RESET = 8'h0E;
endpackage

// File: rtl/wpc_thresh.sv
// Magnitude-versus-threshold comparator.
// Decides whether |meas| * code exceeds the full-scale constant, with no
// divider. Assumes meas is two's complement; code 0 disables the compare.
module wpc_thresh #(
    parameter int MEAS_W = 16,
    parameter int FS_LSB = 307
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [MEAS_W-1:0] meas,
    input  logic [2:0]               code,
    output logic                     above
);
    localparam int PROD_W = MEAS_W + 3;

    logic [MEAS_W-1:0] mag;
    logic [PROD_W-1:0] prod;

    // Absolute value and scaled product, then the strict compare.
    always_comb begin
        mag   = meas[MEAS_W-1] ? (~meas + 1'b1) : meas;
        prod  = PROD_W'(mag) * PROD_W'(code);
        above = (code != 3'd0) && (prod > PROD_W'(FS_LSB));
    end

    AST_CODE0_NEVER_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'd0) |-> !above); // R2
endmodule

// File: rtl/wpc_seq.sv
// Power-state sequencer: run / sleep / calibration.
// Counts qualifying one-second ticks (line low, measurement small) to decide
// sleep or calibration entry, times the calibration window, and flags the
// tick that completes it. Assumes sec_tick is a single-cycle pulse.
module wpc_seq
    import wpc_pkg::*;
#(
    parameter int SLEEP_SEC = 10,
    parameter int CAL_SEC   = 3600
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    line_hi,
    input  logic    sec_tick,
    input  logic    above,
    input  logic    arm,
    output pstate_t state,
    output logic    cal_fire
);
    localparam int LOW_W = $clog2(SLEEP_SEC + 1);
    localparam int CAL_W = $clog2(CAL_SEC);

    logic [LOW_W-1:0] low_cnt;
    logic [CAL_W-1:0] cal_cnt;
    logic             quiet_tick;

    // A tick that counts toward a low-line interval.
    assign quiet_tick = sec_tick && !line_hi && !above;

    // Completion of the calibration window on its last qualifying tick.
    assign cal_fire = (state == PS_CAL) && quiet_tick &&
                      (cal_cnt == CAL_W'(CAL_SEC - 1));

    // State and interval counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PS_RUN;
            low_cnt <= '0;
            cal_cnt <= '0;
        end else begin
            unique case (state)
                PS_RUN: begin
                    if (line_hi || above) begin
                        low_cnt <= '0;
                    end else if (sec_tick) begin
                        if (low_cnt == LOW_W'(SLEEP_SEC)) begin
                            low_cnt <= '0;
                            cal_cnt <= '0;
                            state   <= arm ? PS_CAL : PS_SLEEP;
                        end else begin
                            low_cnt <= low_cnt + 1'b1;
                        end
                    end
                end
                PS_SLEEP: begin
                    if (line_hi) begin
                        state   <= PS_RUN;
                        low_cnt <= '0;
                    end
                end
                PS_CAL: begin
                    if (line_hi || above) begin
                        state   <= PS_RUN;
                        low_cnt <= '0;
                    end else if (cal_fire) begin
                        state   <= PS_SLEEP;
                        cal_cnt <= '0;
                    end else if (sec_tick) begin
                        cal_cnt <= cal_cnt + 1'b1;
                    end
                end
                default: state <= PS_RUN;
            endcase
        end
    end

    AST_STAY_RUN_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && (line_hi || above)) |=> (state == PS_RUN)); // R4
    AST_LINE_HIGH_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_RUN && line_hi) |=> (state == PS_RUN)); // R5
    AST_CAL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_CAL && above) |=> (state == PS_RUN)); // R8
endmodule

// File: rtl/wpc_regs.sv
// Mode and offset registers with host write and calibration update.
// A host write takes the whole mode byte; otherwise a completed calibration
// clears the arm bit and loads the saturated measurement as the offset.
module wpc_regs
    import wpc_pkg::*;
#(
    parameter int MEAS_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_we,
    input  logic [7:0]               mode_wdata,
    input  logic                     cal_fire,
    input  logic signed [MEAS_W-1:0] meas,
    output logic [7:0]               mode_q,
    output logic [7:0]               ofs_q,
    output logic                     done_q
);
    logic [7:0] ofs_sat;

    // Clamp the measurement into the signed byte range.
    always_comb begin
        if (meas > MEAS_W'(signed'(127)))
            ofs_sat = 8'h7F;
        else if (meas < -MEAS_W'(signed'(128)))
            ofs_sat = 8'h80;
        else
            ofs_sat = meas[7:0];
    end

    // Register updates from the host and from calibration completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
            ofs_q  <= 8'h00;
            done_q <= 1'b0;
        end else begin
            done_q <= cal_fire;
            if (cal_fire)
                ofs_q <= ofs_sat;
            if (mode_we)
                mode_q <= mode_wdata;
            else if (cal_fire)
                mode_q[ARM_BIT] <= 1'b0;
        end
    end

    AST_OFS_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_fire |=> $stable(ofs_q)); // R8
    AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_fire && !mode_we) |=> !mode_q[ARM_BIT]); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
endmodule

// File: rtl/activity_power_ctrl.sv
// Top of the activity threshold and power state controller.
// Joins the threshold comparator, sequencer and registers, and registers
// the open-drain wake drive. Assumes sense_val already includes offset.
module activity_power_ctrl
    import wpc_pkg::*;
#(
    parameter int MEAS_W    = 16,
    parameter int FS_LSB    = 307,
    parameter int SLEEP_SEC = 10,
    parameter int CAL_SEC   = 3600
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [MEAS_W-1:0] sense_val,
    input  logic                     line_hi,
    input  logic                     sec_tick,
    input  logic                     mode_we,
    input  logic [7:0]               mode_wdata,
    output logic                     wake_pull_low,
    output logic                     count_en,
    output logic [7:0]               offset_q,
    output logic [7:0]               mode_q,
    output logic                     cal_done
);
    logic    above;
    logic    cal_fire;
    pstate_t state;

    wpc_thresh #(.MEAS_W(MEAS_W), .FS_LSB(FS_LSB)) u_thresh (
        .clk   (clk),
        .rst_n (rst_n),
        .meas  (sense_val),
        .code  (mode_q[CODE_LSB +: CODE_W]),
        .above (above)
    );

    wpc_seq #(.SLEEP_SEC(SLEEP_SEC), .CAL_SEC(CAL_SEC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_hi  (line_hi),
        .sec_tick (sec_tick),
        .above    (above),
        .arm      (mode_q[ARM_BIT]),
        .state    (state),
        .cal_fire (cal_fire)
    );

    wpc_regs #(.MEAS_W(MEAS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .cal_fire   (cal_fire),
        .meas       (sense_val),
        .mode_q     (mode_q),
        .ofs_q      (offset_q),
        .done_q     (cal_done)
    );

    // Registered wake drive follows the threshold decision.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_pull_low <= 1'b0;
        else        wake_pull_low <= above;
    end

    // Counting runs only in the run state.
    assign count_en = (state == PS_RUN);

    AST_ZERO_CODE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3:1] == 3'd0) |=> !wake_pull_low); // R2
    AST_SLEEP_STOPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fire |=> !count_en); // R7
endmodule

// File: tb/tb_activity_power_ctrl.sv
module tb_activity_power_ctrl;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] sense_val = '0;
    logic               line_hi = 1'b1;
    logic               sec_tick = 1'b0;
    logic               mode_we = 1'b0;
    logic [7:0]         mode_wdata = '0;
    logic               wake_pull_low, count_en, cal_done;
    logic [7:0]         offset_q, mode_q;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state (0 run, 1 sleep, 2 cal)
    int m_state, m_low, m_cal, m_mode, m_ofs, m_wake, m_done;

    activity_power_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sense_val(sense_val), .line_hi(line_hi),
        .sec_tick(sec_tick), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .wake_pull_low(wake_pull_low), .count_en(count_en),
        .offset_q(offset_q), .mode_q(mode_q), .cal_done(cal_done)
    );

    always #4 clk = ~clk;

    function automatic int is_big(int v, int mode);
        int code = (mode >> 1) & 7;
        int mag = (v < 0) ? -v : v;
        return (code != 0 && mag * code > 307) ? 1 : 0;
    endfunction

    function automatic int clamp8(int v);
        if (v > 127) return 8'h7F;
        if (v < -128) return 8'h80;
        return v & 8'hFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model advanced on every clock edge.
    always @(posedge clk) begin
        int big, lineh, tk, nmode, fire;
        if (!rst_n) begin
            m_state = 0; m_low = 0; m_cal = 0; m_mode = 8'h0E;
            m_ofs = 0; m_wake = 0; m_done = 0;
        end else begin
            big = is_big(int'(sense_val), m_mode);
            lineh = line_hi; tk = sec_tick;
            fire = 0;
            nmode = m_mode;
            if (m_state == 0) begin
                if (lineh || big) m_low = 0;
                else if (tk) begin
                    if (m_low == 10) begin
                        m_low = 0; m_cal = 0;
                        m_state = ((m_mode >> 6) & 1) ? 2 : 1;
                    end else m_low++;
                end
            end else if (m_state == 1) begin
                if (lineh) begin m_state = 0; m_low = 0; end
            end else begin
                if (lineh || big) begin m_state = 0; m_low = 0; end
                else if (tk) begin
                    if (m_cal == 3599) begin fire = 1; m_state = 1; m_cal = 0; end
                    else m_cal++;
                end
            end
            if (fire) m_ofs = clamp8(int'(sense_val));
            if (mode_we) nmode = mode_wdata;
            else if (fire) nmode = m_mode & ~8'h40;
            m_mode = nmode;
            m_done = fire;
            m_wake = big;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 wake", wake_pull_low, m_wake);
            check("R4 count_en", count_en, (m_state == 0) ? 1 : 0);
            check("R7 cal_done", cal_done, m_done);
            check("R7 offset", offset_q, m_ofs);
            check("R9 mode", mode_q, m_mode);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            sec_tick = 1'b1; step(1);
            sec_tick = 1'b0; step(1);
        end
    endtask

    task automatic wr_mode(int v);
        mode_we = 1'b1; mode_wdata = 8'(v); step(1);
        mode_we = 1'b0; step(1);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 mode", mode_q, 8'h0E);
        check("R1 offset", offset_q, 0);
        check("R1 wake", wake_pull_low, 0);
        check("R1 count_en", count_en, 1);
        check("R1 done", cal_done, 0);

        // R2/R3 thresholds at code 7: 43*7=301, 44*7=308
        sense_val = 16'sd44;  step(2); check("R2 code7 +44", wake_pull_low, 1);
        sense_val = -16'sd44; step(2); check("R2 code7 -44", wake_pull_low, 1);
        sense_val = 16'sd43;  step(2); check("R3 code7 +43", wake_pull_low, 0);
        wr_mode(8'h02);
        sense_val = 16'sd307;  step(2); check("R2 code1 =FS", wake_pull_low, 0);
        sense_val = 16'sd308;  step(2); check("R2 code1 +308", wake_pull_low, 1);
        sense_val = -16'sd308; step(2); check("R3 code1 -308", wake_pull_low, 1);
        wr_mode(8'h00);
        sense_val = 16'sd30000; step(2); check("R2 code0", wake_pull_low, 0);

        // R4 sleep entry with an interrupted low interval
        wr_mode(8'h0E);
        sense_val = 16'sd10;
        line_hi = 1'b0;
        ticks(10);
        line_hi = 1'b1; step(1); line_hi = 1'b0;
        ticks(10);
        check("R4 ten ticks still run", count_en, 1);
        ticks(1);
        check("R4 sleep after eleventh", count_en, 0);

        // R5 exit on line high
        line_hi = 1'b1; step(1);
        check("R5 resume", count_en, 1);

        // R6/R7 full calibration
        wr_mode(8'h4E);
        sense_val = -16'sd5;
        line_hi = 1'b0;
        ticks(11);
        check("R6 cal stops count", count_en, 0);
        check("R6 arm kept", mode_q, 8'h4E);
        ticks(3599);
        check("R7 not yet latched", offset_q, 0);
        ticks(1);
        check("R7 offset latched", offset_q, 8'hFB);
        check("R7 arm cleared", mode_q, 8'h0E);
        check("R7 sleeping after", count_en, 0);
        line_hi = 1'b1; step(1);

        // R8 abort by a large measurement
        wr_mode(8'h4E);
        line_hi = 1'b0;
        ticks(11);
        ticks(100);
        sense_val = 16'sd200; step(1);
        check("R8 back to run", count_en, 1);
        check("R8 offset kept", offset_q, 8'hFB);
        check("R8 arm kept", mode_q, 8'h4E);
        line_hi = 1'b1; step(2);

        // R10 saturation, code 0 so any measurement stays small
        wr_mode(8'h40);
        sense_val = -16'sd500;
        line_hi = 1'b0;
        ticks(3611);
        check("R10 negative clamp", offset_q, 8'h80);
        line_hi = 1'b1; step(1);
        wr_mode(8'h40);
        sense_val = 16'sd300;
        line_hi = 1'b0;
        ticks(3611);
        check("R10 positive clamp", offset_q, 8'h7F);
        line_hi = 1'b1; step(2);

        finish_run();
    end
endmodule